// File: doc/BRIEF.md
# Snooping Three-State Cache Coherence Controller

This block keeps one small direct-mapped data cache coherent with its peers on a shared snooping bus. Each line is invalid, shared (a clean, read-only copy) or modified (the only copy, writable and newer than memory). Two independent event streams move a line between these states. One is the local processor's loads and stores. The other is the stream of transactions that other caches place on the bus, which this controller watches.

On the processor side a one-cycle request carries a write flag, an address and write data. The controller answers with a one-cycle ready pulse and the read data. On the bus side it raises a request and holds a command (read miss, write miss or writeback), an address and data until the arbiter grants it. A granted miss then waits for a completion strobe that carries the line data. The snoop port receives the other caches' granted transactions. When a snoop hits a modified line, the controller answers one cycle later with a flush strobe and the block. The memory model drops its own answer in favour of that block and stores it. Each line holds one data word, so a fill or a flush moves the whole line in one beat.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `bus_req` are low, and the first access to any address costs one bus transaction.
- R2: A read that hits a shared or modified line, or a write that hits a modified line, completes with `cpu_ready` two clock edges after the request edge and issues no bus transaction. A read returns the cached word, and a write updates the line in place.
- R3: A read miss requests the bus with command 2'b01 (read miss) and the requested address. It returns the word delivered with `bus_done` and leaves the line shared.
- R4: A miss whose victim line is modified first requests the bus with command 2'b11 (writeback). That request carries the victim's address and data, and the miss is issued only after it.
- R5: A write that hits a shared line issues command 2'b10 (write miss) before completing and leaves the line modified. A `bus_req` not yet granted keeps its command and address stable.
- R6: A write to an absent line issues one write miss (2'b10), with no other transaction when the victim is clean, and leaves the line modified.
- R7: A snooped read miss (2'b01) that matches a modified line raises `snp_flush` with the line's word on the next cycle and downgrades the line to shared. A match on a shared line causes no flush.
- R8: A snooped write miss (2'b10) that matches a shared line invalidates it. A match on a modified line flushes its word on the next cycle and then invalidates it. Snooped writebacks (2'b11) are ignored.
- R9: When two caches write a line they both share in the same cycle, the arbiter's order decides. The loser receives the winner's flushed word and then applies its own write. Afterwards exactly one cache holds the line modified.
- R10: A snooped transaction to the index of a lookup in progress takes priority. The lookup waits one cycle and then decides on the line state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle processor request strobe, taken while idle |
| cpu_we | input | 1 | Request is a store |
| cpu_addr | input | ADDR_W | Request address, low bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, or the stored word for a store |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Arbiter grant; the transaction happens in the grant cycle |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_done | input | 1 | Miss completion strobe |
| bus_rdata | input | DATA_W | Line word delivered with `bus_done` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the block and memory must not answer |
| snp_data | output | DATA_W | Supplied block word |

## Verification
The two functions that can meet in one cycle are the processor lookup and the snoop update of the same line. The bench provokes this with two controllers. It issues a store on one and, one cycle later, a load of the same address on the other. This places the second cache's lookup exactly in the cycle where the first cache's write miss is granted and snooped. The load passes only if it returns the newly stored word after its own read miss. A hit on the stale shared copy, with no bus traffic, fails it. The same bench also sends two stores to a shared line in one cycle, and judges the arbitration order by the loser's final value and by which cache can then write without the bus.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_WR = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_VICT, F_ISSUE, F_WAIT} fsm_t;
  fsm_t fsm;

  logic [LINES-1:0][1:0] st_q;
  logic [TAG_W-1:0]      tag_q [LINES];
  logic [DATA_W-1:0]     dat_q [LINES];

  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  logic [IDX_W-1:0] r_idx, s_idx;
  logic [TAG_W-1:0] r_tag, s_tag;
  logic hit, s_hit, s_clash, wr_en;
  logic [DATA_W-1:0] wr_val;

  assign r_idx = r_addr[IDX_W-1:0];
  assign r_tag = r_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  assign hit     = (st_q[r_idx] != ST_I) && (tag_q[r_idx] == r_tag);
  assign s_hit   = snp_valid && (snp_cmd == CMD_RD || snp_cmd == CMD_WR) &&
                   (st_q[s_idx] != ST_I) && (tag_q[s_idx] == s_tag);
  assign s_clash = snp_valid && (s_idx == r_idx);

  assign wr_en  = (fsm == F_LOOK && !s_clash && hit && r_we && st_q[r_idx] == ST_M) ||
                  (fsm == F_WAIT && bus_done);
  assign wr_val = r_we ? r_wdata : bus_rdata;

  assign bus_req   = (fsm == F_VICT && st_q[r_idx] == ST_M) || (fsm == F_ISSUE);
  assign bus_cmd   = (fsm == F_VICT) ? CMD_WB : (fsm == F_ISSUE) ? (r_we ? CMD_WR : CMD_RD) : CMD_NONE;
  assign bus_addr  = (fsm == F_VICT) ? {tag_q[r_idx], r_idx} : r_addr;
  assign bus_wdata = dat_q[r_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dat_q[r_idx] <= wr_val;
      tag_q[r_idx] <= r_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      st_q      <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      snp_flush <= 1'b0;
      snp_data  <= '0;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      snp_flush <= s_hit && (st_q[s_idx] == ST_M);
      snp_data  <= dat_q[s_idx];
      if (s_hit)
        st_q[s_idx] <= (snp_cmd == CMD_RD) ? ST_S : ST_I;
      case (fsm)
        F_IDLE: if (cpu_req) begin
          r_we    <= cpu_we;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          fsm     <= F_LOOK;
        end
        F_LOOK: if (!s_clash) begin
          if (hit && (!r_we || st_q[r_idx] == ST_M)) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= r_we ? r_wdata : dat_q[r_idx];
            fsm       <= F_IDLE;
          end else if (!hit && st_q[r_idx] == ST_M) begin
            fsm <= F_VICT;
          end else begin
            fsm <= F_ISSUE;
          end
        end
        F_VICT: begin
          if (st_q[r_idx] != ST_M) begin
            fsm <= F_ISSUE;
          end else if (bus_gnt) begin
            st_q[r_idx] <= ST_I;
            fsm         <= F_ISSUE;
          end
        end
        F_ISSUE: if (bus_gnt) fsm <= F_WAIT;
        F_WAIT: if (bus_done) begin
          st_q[r_idx] <= r_we ? ST_M : ST_S;
          cpu_ready   <= 1'b1;
          cpu_rdata   <= wr_val;
          fsm         <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

module msi_snoop_chk #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_ready,
  input logic                  bus_req,
  input logic                  bus_gnt,
  input logic [1:0]            bus_cmd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  snp_valid,
  input logic [1:0]            snp_cmd,
  input logic [ADDR_W-1:0]     snp_addr,
  input logic                  snp_flush,
  input logic [LINES-1:0][1:0] st
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cpu_ready && !bus_req);

  a_r2_ready_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r3_req_carries_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_cmd != 2'd0);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  a_r7_flush_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> $past(snp_valid) && ($past(snp_cmd) == 2'd1 || $past(snp_cmd) == 2'd2));

  a_r7_read_flush_shares: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush && $past(snp_cmd) == 2'd1 |-> st[$past(snp_addr[IDX_W-1:0])] == 2'd1);

  a_r8_write_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush && $past(snp_cmd) == 2'd2 |-> st[$past(snp_addr[IDX_W-1:0])] == 2'd0);
endmodule

bind msi_snoop_ctrl msi_snoop_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_flush(snp_flush), .st(st_q)
);

// File: tb/msi_snoop_ctrl_tb_top.sv
module msi_snoop_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] c_req, c_we, c_rdy, b_req, gnt, done, s_v, fl;
  logic [7:0] c_addr [2];
  logic [7:0] c_wd   [2];
  logic [7:0] c_rd   [2];
  logic [1:0] b_cmd  [2];
  logic [7:0] b_addr [2];
  logic [7:0] b_wd   [2];
  logic [7:0] fd     [2];
  logic [7:0] rdat;

  logic [7:0]   mem [256];
  logic [255:0] mem_ok;
  logic         mem_clr = 1'b1;
  logic         pend;
  logic         pend_id;
  logic [7:0]   pend_addr;
  logic         tx_id;

  int n_chk = 0, n_fail = 0;
  int tx_n = 0, wb_n = 0, fl_n = 0;

  initial begin
    c_req = '0; c_we = '0;
    c_addr[0] = '0; c_addr[1] = '0; c_wd[0] = '0; c_wd[1] = '0;
  end

  always_comb begin
    gnt[0] = !pend && b_req[0];
    gnt[1] = !pend && b_req[1] && !b_req[0];
    tx_id  = gnt[1];
    s_v[0] = gnt[1];
    s_v[1] = gnt[0];
    done[0] = pend && !pend_id;
    done[1] = pend && pend_id;
    rdat = fl[0] ? fd[0] : fl[1] ? fd[1] :
           (mem_ok[pend_addr] ? mem[pend_addr] : (pend_addr ^ 8'h10));
  end

  always @(posedge clk) begin
    if (mem_clr) mem_ok <= '0;
    if (!rst_n) pend <= 1'b0;
    else begin
      if (|gnt) begin
        tx_n <= tx_n + 1;
        if (b_cmd[tx_id] == 2'd3) begin
          wb_n <= wb_n + 1;
          mem[b_addr[tx_id]] <= b_wd[tx_id];
          mem_ok[b_addr[tx_id]] <= 1'b1;
        end else begin
          pend <= 1'b1;
          pend_id <= tx_id;
          pend_addr <= b_addr[tx_id];
        end
      end
      if (pend) begin
        pend <= 1'b0;
        if (|fl) begin
          mem[pend_addr] <= rdat;
          mem_ok[pend_addr] <= 1'b1;
        end
      end
      if (|fl) fl_n <= fl_n + 1;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_c
    msi_snoop_ctrl #(.ADDR_W(8), .DATA_W(8), .LINES(4)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(c_req[k]), .cpu_we(c_we[k]), .cpu_addr(c_addr[k]), .cpu_wdata(c_wd[k]),
      .cpu_rdata(c_rd[k]), .cpu_ready(c_rdy[k]),
      .bus_req(b_req[k]), .bus_gnt(gnt[k]), .bus_cmd(b_cmd[k]), .bus_addr(b_addr[k]),
      .bus_wdata(b_wd[k]), .bus_done(done[k]), .bus_rdata(rdat),
      .snp_valid(s_v[k]), .snp_cmd(b_cmd[1-k]), .snp_addr(b_addr[1-k]),
      .snp_flush(fl[k]), .snp_data(fd[k])
    );
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // called just after a negedge
  task automatic op(input int id, input logic we, input logic [7:0] a, input logic [7:0] wd,
                    output logic [7:0] rd, output int lat);
    c_req[id] = 1'b1; c_we[id] = we; c_addr[id] = a; c_wd[id] = wd;
    @(negedge clk);
    c_req[id] = 1'b0;
    lat = 1;
    rd = 8'hxx;
    while (!c_rdy[id] && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    if (c_rdy[id]) rd = c_rd[id];
    else chk("op", "ready timeout", 0, 1);
  endtask

  // {cache, we, addr, wdata, expected word, bus txns, writebacks, flushes}
  localparam logic [30:0] VEC [18] = '{
    {1'b0, 1'b0, 8'h10, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h10, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h10, 8'h01, 8'h01, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h10, 8'h00, 8'h01, 3'd1, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h10, 8'h00, 8'h01, 3'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h10, 8'h00, 8'h01, 3'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h10, 8'h05, 8'h05, 3'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h10, 8'h06, 8'h06, 3'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h20, 8'h00, 8'h30, 3'd2, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h10, 8'h00, 8'h06, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h21, 8'h09, 8'h09, 3'd1, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h21, 8'h00, 8'h09, 3'd1, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h21, 8'h44, 8'h44, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h21, 8'h00, 8'h44, 3'd1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h32, 8'h07, 8'h07, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h32, 8'h08, 8'h08, 3'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h32, 8'hAA, 8'hAA, 3'd1, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h32, 8'h00, 8'hAA, 3'd1, 1'b0, 1'b1}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1:        return "R3";
      2, 6, 12:    return "R5";
      3, 11:       return "R7";
      4, 5:        return "R2";
      7, 15:       return "R2/R5";
      8, 9:        return "R4";
      10, 14:      return "R6";
      default:     return "R8";
    endcase
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin : main
    logic [7:0] rd, rd2;
    int lat, lat2, t0, w0, f0;
    repeat (3) @(negedge clk);
    mem_clr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk("R1", "ready after reset", int'(c_rdy), 0);
    chk("R1", "bus_req after reset", int'(b_req), 0);

    for (int i = 0; i < 18; i++) begin
      t0 = tx_n; w0 = wb_n; f0 = fl_n;
      op(int'(VEC[i][30]), VEC[i][29], VEC[i][28:21], VEC[i][20:13], rd, lat);
      @(negedge clk);
      chk(row_tag(i), "word", int'(rd), int'(VEC[i][12:5]));
      chk(row_tag(i), "bus txns", tx_n - t0, int'(VEC[i][4:2]));
      chk(row_tag(i), "writebacks", wb_n - w0, int'(VEC[i][1]));
      chk(row_tag(i), "flushes", fl_n - f0, int'(VEC[i][0]));
      if (VEC[i][4:2] == 3'd0) chk("R2", "hit latency", lat, 2);
    end

    // R9: simultaneous writers to a shared line
    op(0, 1'b0, 8'h13, 8'h00, rd, lat);
    chk("R9", "prep word A", int'(rd), 8'h03);
    op(1, 1'b0, 8'h13, 8'h00, rd, lat);
    chk("R9", "prep word B", int'(rd), 8'h03);
    t0 = tx_n; f0 = fl_n;
    fork
      op(0, 1'b1, 8'h13, 8'h11, rd, lat);
      op(1, 1'b1, 8'h13, 8'h22, rd2, lat2);
    join
    @(negedge clk);
    chk("R9", "two write misses", tx_n - t0, 2);
    chk("R9", "winner flushed once", fl_n - f0, 1);
    chk("R9", "loser finishes later", int'(lat2 > lat), 1);
    t0 = tx_n;
    op(1, 1'b1, 8'h13, 8'h23, rd, lat);
    chk("R9", "loser holds line modified", tx_n - t0, 0);
    t0 = tx_n;
    op(0, 1'b0, 8'h13, 8'h00, rd, lat);
    chk("R9", "winner lost its copy", tx_n - t0, 1);
    chk("R9", "winner reads loser word", int'(rd), 8'h23);

    // R1: reset in mid-run invalidates every line
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after second reset", int'(c_rdy), 0);
    chk("R1", "bus_req after second reset", int'(b_req), 0);
    t0 = tx_n;
    op(0, 1'b0, 8'h10, 8'h00, rd, lat);
    chk("R1", "miss after reset", tx_n - t0, 1);
    chk("R1", "word from memory", int'(rd), 8'h06);

    // R10: lookup and snoop to one index in the same cycle
    op(1, 1'b0, 8'h10, 8'h00, rd, lat);
    chk("R10", "prep shared copy", int'(rd), 8'h06);
    t0 = tx_n; f0 = fl_n;
    fork
      op(0, 1'b1, 8'h10, 8'h77, rd, lat);
      begin
        @(negedge clk);
        op(1, 1'b0, 8'h10, 8'h00, rd2, lat2);
      end
    join
    @(negedge clk);
    chk("R10", "reader sees new word", int'(rd2), 8'h77);
    chk("R10", "write miss plus read miss", tx_n - t0, 2);
    chk("R10", "writer flushed", fl_n - f0, 1);

    summary();
  end
endmodule